// File: doc/BRIEF.md
# Parallel Flash Programming Command Controller

This controller sits behind the parallel pins a flash programmer drives: chip enable, output enable, write enable, a program/erase enable level, a 19-bit address and an 8-bit data bus. It brings every pin into the system clock domain through two flops. It decides whether each bus cycle is a read, an output-disabled cycle, a command write or a deselected cycle. It then runs a small command sequencer that spans several bus cycles. The read path either returns array data at the applied address or returns a status byte. The data bus is driven only during a read cycle.

Program and erase run as a request/acknowledge exchange with a backend that owns the array. For a program, the sequencer collects a 128-byte page into a local buffer. The backend reads that buffer through an index port and takes the page number from `pg_base`. The controller raises a request that stays high until the backend returns a one-cycle acknowledge. While a request is open, the controller reports busy and takes no command writes.

Top module: `flash_cmd_if`

## Requirements
- R1: With chip enable low, output enable low and write enable high, `dq_oe` is 1 and `dq_out` carries the read data for the applied address: array data from `array_rdata`, with `array_addr` equal to the pin address, or the status byte in status mode.
- R2: With chip enable low and both output enable and write enable high, `dq_oe` is 0.
- R3: With chip enable high, `dq_oe` is 0 and write-enable strobes have no effect. A command sequence that was started before the deselected cycles continues when chip enable returns low.
- R4: A command write is taken on the rising edge of write enable, as seen after synchronisation, while chip enable is low and output enable is high. It uses the address and data present at that moment.
- R5: Opcode 0x00 selects memory read mode, in which reads return array data. It also clears the error flag. Memory read mode is the mode after reset.
- R6: Opcode 0x71 written in two consecutive command writes selects status mode. In status mode, reads return the status byte, where bit 7 is busy, bit 4 is command error and all other bits are 0.
- R7: Opcode 0x20 written twice in a row, with the enable pin high, raises `erase_req` and switches reads to the status byte.
- R8: Opcode 0x40 followed by 128 data writes stores each byte at buffer index address[6:0]. The page number address[18:7] is taken from the first data write. After the 128th byte, `prog_req` rises and reads switch to the status byte. `pb_data` returns buffer entry `pb_idx`.
- R9: While the enable pin is low, a write of opcode 0x40 or 0x20, an erase confirm, or a page data byte has no effect.
- R10: An unknown opcode, or a second write that does not repeat the 0x20 or 0x71 opcode, sets the error flag and returns the sequencer to memory read mode.
- R11: While `prog_req` or `erase_req` is high, busy is 1 and every command write is ignored. The two requests are never high together.
- R12: A request stays high until `backend_ack` is seen. The acknowledge clears the request and busy, and the status byte then reads 0x00 if there is no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable pin, active low |
| oe_n | input | 1 | Output enable pin, active low |
| we_n | input | 1 | Write enable pin, active low |
| fwe | input | 1 | Program/erase enable level, active high |
| addr | input | 19 | Address pins |
| dq_in | input | 8 | Data bus input |
| dq_out | output | 8 | Data bus output value |
| dq_oe | output | 1 | Data bus drive enable |
| array_addr | output | 19 | Read address to the array |
| array_rdata | input | 8 | Array read data |
| pg_base | output | 12 | Page number of the loaded page |
| pb_idx | input | 7 | Page buffer read index from the backend |
| pb_data | output | 8 | Page buffer read data |
| prog_req | output | 1 | Program request |
| erase_req | output | 1 | Erase request |
| backend_ack | input | 1 | One-cycle completion acknowledge |

## Verification
The pin checks assume that every strobe and bus level stays steady for at least three clocks. This lets a pin level seen two clocks earlier predict the synchronised state. The bench holds every bus phase for four clocks. The erase check also assumes that the enable pin does not move in the cycles around a confirm write, and the bench changes that pin only between complete writes. The acknowledge is assumed to arrive only while a request is open, and the bench pulses it once, after checking that the request is still high.

// File: rtl/flash_cmd_if.sv
module flash_cmd_if #(
  parameter int AW   = 19,
  parameter int PAGE = 128
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         ce_n,
  input  logic                         oe_n,
  input  logic                         we_n,
  input  logic                         fwe,
  input  logic [AW-1:0]                addr,
  input  logic [7:0]                   dq_in,
  output logic [7:0]                   dq_out,
  output logic                         dq_oe,
  output logic [AW-1:0]                array_addr,
  input  logic [7:0]                   array_rdata,
  output logic [AW-$clog2(PAGE)-1:0]   pg_base,
  input  logic [$clog2(PAGE)-1:0]      pb_idx,
  output logic [7:0]                   pb_data,
  output logic                         prog_req,
  output logic                         erase_req,
  input  logic                         backend_ack
);
  localparam int IW = $clog2(PAGE);
  localparam int SW = AW + 12;
  localparam logic [7:0] OP_READ = 8'h00;
  localparam logic [7:0] OP_PROG = 8'h40;
  localparam logic [7:0] OP_ERS  = 8'h20;
  localparam logic [7:0] OP_STAT = 8'h71;
  localparam logic [SW-1:0] SYNC_RST = {4'b0111, {(AW+8){1'b0}}};

  typedef enum logic [2:0] {M_READ, M_STAT, M_ERS, M_STC, M_PROG} mode_t;

  logic [SW-1:0] m1, m2;
  logic          s_fwe, s_we, s_oe, s_ce, we_d, err, busy, wr_evt;
  logic [AW-1:0] s_addr;
  logic [7:0]    s_din;
  logic [IW-1:0] cnt;
  mode_t         mode;
  logic [7:0]    pbuf [PAGE];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      m1 <= SYNC_RST;
      m2 <= SYNC_RST;
    end else begin
      m1 <= {fwe, we_n, oe_n, ce_n, addr, dq_in};
      m2 <= m1;
    end

  assign {s_fwe, s_we, s_oe, s_ce, s_addr, s_din} = m2;

  assign busy       = prog_req | erase_req;
  assign wr_evt     = s_we & ~we_d & ~s_ce & s_oe & ~busy;
  assign dq_oe      = ~s_ce & ~s_oe & s_we;
  assign dq_out     = (mode == M_STAT) ? {busy, 2'b00, err, 4'b0000} : array_rdata;
  assign array_addr = s_addr;
  assign pb_data    = pbuf[pb_idx];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      we_d      <= 1'b1;
      mode      <= M_READ;
      err       <= 1'b0;
      cnt       <= '0;
      pg_base   <= '0;
      prog_req  <= 1'b0;
      erase_req <= 1'b0;
    end else begin
      we_d <= s_we;
      if (busy && backend_ack) begin
        prog_req  <= 1'b0;
        erase_req <= 1'b0;
      end
      if (wr_evt) begin
        case (mode)
          M_READ, M_STAT: begin
            case (s_din)
              OP_READ: begin mode <= M_READ; err <= 1'b0; end
              OP_STAT: mode <= M_STC;
              OP_ERS:  if (s_fwe) mode <= M_ERS;
              OP_PROG: if (s_fwe) begin mode <= M_PROG; cnt <= '0; end
              default: begin mode <= M_READ; err <= 1'b1; end
            endcase
          end
          M_STC: begin
            if (s_din == OP_STAT) mode <= M_STAT;
            else begin mode <= M_READ; err <= 1'b1; end
          end
          M_ERS: if (s_fwe) begin
            if (s_din == OP_ERS) begin
              erase_req <= 1'b1;
              mode      <= M_STAT;
            end else begin
              mode <= M_READ;
              err  <= 1'b1;
            end
          end
          M_PROG: if (s_fwe) begin
            if (cnt == '0) pg_base <= s_addr[AW-1:IW];
            cnt <= cnt + 1'b1;
            if (cnt == IW'(PAGE-1)) begin
              prog_req <= 1'b1;
              mode     <= M_STAT;
            end
          end
          default: mode <= M_READ;
        endcase
      end
    end

  always_ff @(posedge clk)
    if (wr_evt && mode == M_PROG && s_fwe) pbuf[s_addr[IW-1:0]] <= s_din;

endmodule

// File: rtl/flash_cmd_if_chk.sv
module flash_cmd_if_chk #(
  parameter int BW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ce_n,
  input logic          oe_n,
  input logic          fwe,
  input logic          dq_oe,
  input logic          prog_req,
  input logic          erase_req,
  input logic          backend_ack,
  input logic [BW-1:0] pg_base
);
  AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n, 2) |-> !dq_oe);  // R3
  AST_OE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(oe_n, 2) |-> !dq_oe);  // R2
  AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(prog_req && erase_req));  // R11
  AST_PROG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_req && !backend_ack) |=> prog_req);  // R12
  AST_ERS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_req && !backend_ack) |=> erase_req);  // R12
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    ((prog_req || erase_req) && backend_ack) |=> !(prog_req || erase_req));  // R12
  AST_BASE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    prog_req |=> $stable(pg_base));  // R8
  AST_ERS_NEEDS_FWE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(erase_req) |-> $past(fwe, 3));  // R9
endmodule

bind flash_cmd_if flash_cmd_if_chk #(.BW(AW - $clog2(PAGE))) chk (
  .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .fwe(fwe),
  .dq_oe(dq_oe), .prog_req(prog_req), .erase_req(erase_req),
  .backend_ack(backend_ack), .pg_base(pg_base)
);

// File: tb/flash_cmd_if_test.sv
module flash_cmd_if_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, fwe = 1'b0;
  logic [18:0] addr = '0;
  logic [7:0]  dq_in = '0;
  logic [7:0]  dq_out, array_rdata, pb_data;
  logic        dq_oe, prog_req, erase_req;
  logic        backend_ack = 1'b0;
  logic [18:0] array_addr;
  logic [11:0] pg_base;
  logic [6:0]  pb_idx = '0;
  logic        sel = 1'b0;
  int checks = 0, errors = 0;

  typedef struct { logic [8:0] exp; string tag; } item_t;
  item_t sbq[$];
  event  smp;

  localparam logic [11:0] BASE = 12'h3A5;

  always #10 clk = ~clk;

  function automatic logic [7:0] amodel(input logic [18:0] a);
    return a[7:0] ^ a[15:8] ^ {5'b0, a[18:16]} ^ 8'hA5;
  endfunction

  assign array_rdata = amodel(array_addr);

  flash_cmd_if uut (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .fwe(fwe),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe),
    .array_addr(array_addr), .array_rdata(array_rdata), .pg_base(pg_base),
    .pb_idx(pb_idx), .pb_data(pb_data), .prog_req(prog_req),
    .erase_req(erase_req), .backend_ack(backend_ack)
  );

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always begin
    @(smp);
    if (sbq.size() == 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual empty expected item");
    end else begin
      item_t it = sbq.pop_front();
      logic [8:0] obs = sel ? {1'b1, pb_data} : {dq_oe, dq_oe ? dq_out : 8'h00};
      chk({7'b0, obs}, {7'b0, it.exp}, it.tag);
    end
  end

  task automatic expect_now(input logic [8:0] e, input string tag);
    sbq.push_back('{exp: e, tag: tag});
    -> smp;
    #1;
  endtask

  task automatic wr(input logic [18:0] a, input logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b1; addr = a; dq_in = d; we_n = 1'b0;
    repeat (4) @(negedge clk);
    we_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic desel_strobe(input logic [7:0] d);
    @(negedge clk);
    ce_n = 1'b1; oe_n = 1'b1; dq_in = d; we_n = 1'b0;
    repeat (4) @(negedge clk);
    we_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(input logic [18:0] a, input logic [8:0] e, input string tag);
    @(negedge clk);
    ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; addr = a;
    repeat (4) @(negedge clk);
    expect_now(e, tag);
    oe_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic ack_pulse();
    @(negedge clk); backend_ack = 1'b1;
    @(negedge clk); backend_ack = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [18:0] a;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk({15'b0, dq_oe}, 16'h0, "R2 reset bus released");
    chk({14'b0, prog_req, erase_req}, 16'h0, "R12 reset no request");

    rd(19'h12345, {1'b1, amodel(19'h12345)}, "R1 R5 read after reset");
    rd(19'h7FF00, {1'b1, amodel(19'h7FF00)}, "R1 second address");

    @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_now(9'h000, "R2 output disable");
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1;
    repeat (4) @(negedge clk);
    expect_now(9'h000, "R3 deselected read");
    oe_n = 1'b1;

    wr(19'h0, 8'h71);
    desel_strobe(8'h55);
    wr(19'h0, 8'h71);
    rd(19'h00010, 9'h100, "R3 R6 R4 status across deselect");
    wr(19'h0, 8'h00);
    rd(19'h00022, {1'b1, amodel(19'h00022)}, "R5 back to array");

    wr(19'h0, 8'h55);
    wr(19'h0, 8'h71); wr(19'h0, 8'h71);
    rd(19'h0, 9'h110, "R10 unknown opcode error");
    fwe = 1'b1;
    wr(19'h0, 8'h20); wr(19'h0, 8'h00);
    chk({15'b0, erase_req}, 16'h0, "R10 bad erase confirm");
    rd(19'h04444, {1'b1, amodel(19'h04444)}, "R10 mismatch returns to read");
    wr(19'h0, 8'h00);
    wr(19'h0, 8'h71); wr(19'h0, 8'h71);
    rd(19'h0, 9'h100, "R5 error cleared");

    fwe = 1'b0;
    wr(19'h0, 8'h20); wr(19'h0, 8'h20);
    chk({15'b0, erase_req}, 16'h0, "R9 erase blocked by fwe");
    wr(19'h0, 8'h71); wr(19'h0, 8'h71);
    rd(19'h0, 9'h100, "R9 no error from blocked erase");

    fwe = 1'b1;
    wr(19'h0, 8'h20); wr(19'h0, 8'h20);
    chk({14'b0, prog_req, erase_req}, 16'h1, "R7 erase request");
    rd(19'h0, 9'h180, "R7 status busy");
    wr(19'h0, 8'h00);
    rd(19'h0, 9'h180, "R11 write ignored while busy");
    repeat (10) @(negedge clk);
    chk({15'b0, erase_req}, 16'h1, "R12 erase held");
    ack_pulse();
    chk({14'b0, prog_req, erase_req}, 16'h0, "R12 ack clears erase");
    rd(19'h0, 9'h100, "R12 status idle after erase");

    wr(19'h0, 8'h40);
    for (int i = 0; i < 128; i++) begin
      logic [6:0] idx = 7'(127 - i);
      wr({BASE, idx}, 8'(idx * 3 + 7));
      if (i == 10) begin
        fwe = 1'b0;
        wr({BASE, idx}, 8'hEE);
        fwe = 1'b1;
      end
      if (i == 126) chk({15'b0, prog_req}, 16'h0, "R9 R8 no request before last byte");
    end
    chk({14'b0, prog_req, erase_req}, 16'h2, "R8 program request");
    chk({4'b0, pg_base}, {4'b0, BASE}, "R8 page base");
    rd(19'h0, 9'h180, "R8 status busy");
    sel = 1'b1;
    foreach (a[k]) begin end
    for (int j = 0; j < 4; j++) begin
      logic [6:0] ix = (j == 0) ? 7'd0 : (j == 1) ? 7'd117 : (j == 2) ? 7'd127 : 7'd64;
      @(negedge clk); pb_idx = ix;
      @(negedge clk);
      expect_now({1'b1, 8'(ix * 3 + 7)}, "R8 R9 page buffer entry");
    end
    sel = 1'b0;
    wr(19'h0, 8'h20);
    chk({14'b0, prog_req, erase_req}, 16'h2, "R11 no erase while programming");
    ack_pulse();
    chk({15'b0, prog_req}, 16'h0, "R12 ack clears program");
    rd(19'h0, 9'h100, "R12 status idle after program");

    repeat (5) @(negedge clk);
    summary();
  end
endmodule